// File: doc/BRIEF.md
# Flash Command Register State Machine

This block models the command interface of a small byte-wide flash memory. Chip-enable, output-enable and write-enable strobes arrive asynchronously and are brought into the local clock domain together with the address bus and the bidirectional data bus. Each completed write cycle presents one command byte, which a state machine decodes. Program and erase each take a setup write followed by an operation write. The operation write starts a pulse, and a later verify write ends that pulse. A behavioural byte array holds the contents. The array is erased to all ones, and programming can only clear bits.

Reads return array data, the byte under verification, or a two-byte identifier, depending on the current mode. The data bus is left undriven whenever the chip is not selected or its outputs are disabled. Command writes take effect only while the high-voltage-present input is asserted. Without it, the block behaves as a plain read-only memory.

Pulse widths are parameters counted in clock cycles. An internal stop timer ends each pulse even if no verify write arrives. The `supply_ok` input models the low-supply lockout. The array depth defaults to 256 bytes so that elaboration stays small. The address width is a parameter and can be raised to 15 bits for a 32K-byte array.

Top module: `flashcmd_top`

## Requirements
- R1: After reset the block is in array-read mode, `pulse_active` is 0 and every byte reads FFh. The data bus is not driven while `ce_n` or `oe_n` is high.
- R2: A write cycle occurs only while `ce_n` and `we_n` are low and `oe_n` is high. Low `oe_n` blocks it. The address is taken when the write condition starts, and the data when it ends.
- R3: While `hv_ok` is low, completed writes change neither the mode nor the array.
- R4: Command 90h selects identifier mode. A read with address bit 0 at 0 returns 01h, and with address bit 0 at 1 returns A1h.
- R5: Command 20h followed by 20h sets every byte to FFh and starts the erase pulse. Any other byte (except FFh) after the first 20h returns the block to array-read mode.
- R6: Command 40h followed by a write of address and data starts the program pulse. The stored byte becomes the old value ANDed with the new data.
- R7: Command C0h written during a program pulse ends it. Reads then return the programmed byte at any address.
- R8: Command A0h written during an erase pulse ends it. Reads then return the byte at the address given with A0h.
- R9: During a pulse, every write other than the matching verify command or an FFh pair is ignored.
- R10: A pulse ends on its own after `PRG_CYC` (program) or `ERS_CYC` (erase) cycles.
- R11: Two consecutive FFh writes return the block to array-read mode. A single FFh write changes nothing.
- R12: `supply_ok` low forces array-read mode and ends any pulse.
- R13: A write condition already present when reset is released is never accepted.
- R14: Command 00h selects array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| dq | inout | 8 | Bidirectional data bus |
| hv_ok | input | 1 | High programming voltage present |
| supply_ok | input | 1 | Supply above lockout level, synchronous to clk |
| pulse_active | output | 1 | Program or erase pulse in progress |

## Verification
The assertions rely on four assumptions about the inputs:
- Each strobe level is held for several clock cycles.
- Address and data stay stable from before a write condition begins until after it ends.
- `supply_ok` is synchronous to `clk`.
- `ERS_CYC` is not smaller than `PRG_CYC`.

The bench's write task holds each strobe phase for at least three cycles. It keeps the bus driven until chip enable has risen. It changes `supply_ok` only at the falling clock edge. It uses the default pulse widths.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

    typedef enum logic [2:0] {
        M_READ,
        M_IDENT,
        M_ESETUP,
        M_EPULSE,
        M_EVERIFY,
        M_PSETUP,
        M_PPULSE,
        M_PVERIFY
    } mode_e;

    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_EVFY   = 8'hA0;
    localparam logic [7:0] CMD_PROG   = 8'h40;
    localparam logic [7:0] CMD_PVFY   = 8'hC0;
    localparam logic [7:0] CMD_RESET  = 8'hFF;

    localparam logic [7:0] MFR_CODE   = 8'h01;
    localparam logic [7:0] DEV_CODE   = 8'hA1;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } wbyte_t;

    function automatic logic [7:0] ident_byte(input logic sel);
        return sel ? DEV_CODE : MFR_CODE;
    endfunction

    function automatic logic is_verify(input mode_e m);
        return (m == M_EVERIFY) || (m == M_PVERIFY);
    endfunction

endpackage

// File: rtl/flashcmd_strobe.sv
module flashcmd_strobe #(
    parameter int ADDR_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hv_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_done,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic [SYNC_N-1:0]             ce_q, we_q, oe_q, hv_q;
    logic [SYNC_N-1:0][ADDR_W-1:0] a_q;
    logic [SYNC_N-1:0][7:0]        d_q;
    logic                          wr_now, wr_q, started;
    logic [ADDR_W-1:0]             lat_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q <= '0;
            we_q <= '0;
            oe_q <= '1;
            hv_q <= '0;
        end else begin
            ce_q <= {ce_q[SYNC_N-2:0], ce_n};
            we_q <= {we_q[SYNC_N-2:0], we_n};
            oe_q <= {oe_q[SYNC_N-2:0], oe_n};
            hv_q <= {hv_q[SYNC_N-2:0], hv_ok};
        end
    end

    // address and data follow the same delay as the strobes
    always_ff @(posedge clk) begin
        a_q[0] <= addr;
        d_q[0] <= din;
    end

    for (genvar i = 1; i < SYNC_N; i++) begin : g_dly
        always_ff @(posedge clk) begin
            a_q[i] <= a_q[i-1];
            d_q[i] <= d_q[i-1];
        end
    end

    assign wr_now = !ce_q[SYNC_N-1] && !we_q[SYNC_N-1] && oe_q[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b1;
            started  <= 1'b0;
            wr_done  <= 1'b0;
            lat_addr <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_q    <= wr_now;
            wr_done <= 1'b0;
            if (wr_now && !wr_q) begin
                lat_addr <= a_q[SYNC_N-1];
                started  <= 1'b1;
            end
            if (!wr_now && wr_q) begin
                started <= 1'b0;
                if (started && hv_q[SYNC_N-1]) begin
                    wr_done <= 1'b1;
                    wr_addr <= lat_addr;
                    wr_data <= d_q[SYNC_N-1];
                end
            end
        end
    end
endmodule

// File: rtl/flashcmd_ctrl.sv
module flashcmd_ctrl
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PRG_CYC = 40,
    parameter int ERS_CYC = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output mode_e             mode,
    output logic              pulse_active,
    output logic              prog_go,
    output logic              erase_go,
    output logic [ADDR_W-1:0] vaddr,
    output logic [7:0]        pdata
);
    localparam int MAXC = (ERS_CYC > PRG_CYC) ? ERS_CYC : PRG_CYC;
    localparam int TW   = $clog2(MAXC + 1);

    logic [TW-1:0] tmr;
    logic          armed;

    assign pulse_active = (tmr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= M_READ;
            tmr      <= '0;
            armed    <= 1'b0;
            prog_go  <= 1'b0;
            erase_go <= 1'b0;
            vaddr    <= '0;
            pdata    <= '0;
        end else begin
            prog_go  <= 1'b0;
            erase_go <= 1'b0;
            if (tmr != '0) tmr <= tmr - 1'b1;
            if (!supply_ok) begin
                mode  <= M_READ;
                tmr   <= '0;
                armed <= 1'b0;
            end else if (wr_done) begin
                if (mode == M_PSETUP) begin
                    // second program write carries address and data
                    armed   <= 1'b0;
                    prog_go <= 1'b1;
                    vaddr   <= wr_addr;
                    pdata   <= wr_data;
                    tmr     <= TW'(PRG_CYC);
                    mode    <= M_PPULSE;
                end else if (wr_data == CMD_RESET) begin
                    if (armed) begin
                        mode  <= M_READ;
                        tmr   <= '0;
                        armed <= 1'b0;
                    end else begin
                        armed <= 1'b1;
                    end
                end else begin
                    armed <= 1'b0;
                    unique case (mode)
                        M_ESETUP: begin
                            if (wr_data == CMD_ERASE) begin
                                erase_go <= 1'b1;
                                tmr      <= TW'(ERS_CYC);
                                mode     <= M_EPULSE;
                            end else begin
                                mode <= M_READ;
                            end
                        end
                        M_EPULSE: begin
                            if (wr_data == CMD_EVFY) begin
                                tmr   <= '0;
                                vaddr <= wr_addr;
                                mode  <= M_EVERIFY;
                            end
                        end
                        M_PPULSE: begin
                            if (wr_data == CMD_PVFY) begin
                                tmr  <= '0;
                                mode <= M_PVERIFY;
                            end
                        end
                        default: begin
                            case (wr_data)
                                CMD_READ:  mode <= M_READ;
                                CMD_IDENT: mode <= M_IDENT;
                                CMD_ERASE: mode <= M_ESETUP;
                                CMD_PROG:  mode <= M_PSETUP;
                                CMD_PVFY:  mode <= M_PVERIFY;
                                CMD_EVFY: begin
                                    vaddr <= wr_addr;
                                    mode  <= M_EVERIFY;
                                end
                                default: ;
                            endcase
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/flashcmd_array.sv
module flashcmd_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_go,
    input  logic              prog_go,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [7:0]        pdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || erase_go) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (prog_go) begin
            mem[paddr] <= mem[paddr] & pdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/flashcmd_top.sv
module flashcmd_top
    import flashcmd_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int PRG_CYC = 40,
    parameter int ERS_CYC = 400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [7:0]        dq,
    input  logic              hv_ok,
    input  logic              supply_ok,
    output logic              pulse_active
);
    logic              wr_done, prog_go, erase_go, dq_drive;
    logic [ADDR_W-1:0] wr_addr, vaddr, raddr;
    logic [7:0]        wr_data, pdata, arr_rd, rd_q;
    mode_e             mode;

    flashcmd_strobe #(.ADDR_W(ADDR_W), .SYNC_N(2)) strobe_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hv_ok(hv_ok), .addr(addr), .din(dq),
        .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flashcmd_ctrl #(.ADDR_W(ADDR_W), .PRG_CYC(PRG_CYC), .ERS_CYC(ERS_CYC)) ctrl_i (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode(mode), .pulse_active(pulse_active),
        .prog_go(prog_go), .erase_go(erase_go), .vaddr(vaddr), .pdata(pdata)
    );

    assign raddr = is_verify(mode) ? vaddr : addr;

    flashcmd_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst(rst), .erase_go(erase_go), .prog_go(prog_go),
        .paddr(vaddr), .pdata(pdata), .raddr(raddr), .rdata(arr_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 8'hFF;
        else     rd_q <= (mode == M_IDENT) ? ident_byte(addr[0]) : arr_rd;
    end

    assign dq_drive = !ce_n && !oe_n;
    assign dq       = dq_drive ? rd_q : 8'hzz;
endmodule

// File: rtl/flashcmd_chk.sv
module flashcmd_chk
    import flashcmd_pkg::*;
#(
    parameter int ERS_CYC = 400
) (
    input logic  clk,
    input logic  rst,
    input logic  supply_ok,
    input logic  wr_done,
    input logic  pulse_active,
    input logic  dq_drive,
    input logic  ce_n,
    input logic  oe_n,
    input mode_e mode
);
    logic [31:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pulse_active) run_cnt <= '0;
        else                      run_cnt <= run_cnt + 1;
    end

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= ERS_CYC);                                          // R10

    AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_active) |-> $past(wr_done));                      // R5

    AST_MODE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode) |-> ($past(wr_done) || !$past(supply_ok)));    // R3

    AST_LOCKOUT_READ: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (mode == M_READ) && !pulse_active);            // R12

    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> !dq_drive);                                // R1
endmodule

bind flashcmd_top flashcmd_chk #(.ERS_CYC(ERS_CYC)) chk_i (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .wr_done(wr_done),
    .pulse_active(pulse_active), .dq_drive(dq_drive),
    .ce_n(ce_n), .oe_n(oe_n), .mode(mode)
);

// File: tb/flashcmd_top_tb_top.sv
`timescale 1ns/1ps
module flashcmd_top_tb_top;
    localparam int AW = 8;
    localparam int PRG_CYC = 40;
    localparam int ERS_CYC = 400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic hv_ok = 1'b1, supply_ok = 1'b1;
    logic pulse_active;
    logic [7:0] tb_dq = '0;
    logic tb_drive = 1'b0;
    wire  [7:0] dq;
    int   n_chk = 0, n_bad = 0;
    logic done = 1'b0;

    assign dq = tb_drive ? tb_dq : 8'hzz;

    always #4 clk = ~clk;

    flashcmd_top #(.ADDR_W(AW), .PRG_CYC(PRG_CYC), .ERS_CYC(ERS_CYC)) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq(dq), .hv_ok(hv_ok), .supply_ok(supply_ok),
        .pulse_active(pulse_active)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; tb_dq = d; tb_drive = 1'b1; oe_n = 1'b1;
        cyc(1);
        ce_n = 1'b0;
        cyc(1);
        we_n = 1'b0;
        cyc(4);
        we_n = 1'b1;
        cyc(3);
        ce_n = 1'b1;
        cyc(1);
        tb_drive = 1'b0;
        cyc(4);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        cyc(3);
        d = dq;
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(1);
    endtask

    task automatic do_reset(input logic hold_wr);
        @(negedge clk);
        rst = 1'b1;
        if (hold_wr) begin
            addr = '0; tb_dq = 8'h90; tb_drive = 1'b1;
            ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        end
        cyc(4);
        rst = 1'b0;
        cyc(2);
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check("R1 pulse idle", {7'b0, pulse_active}, 8'h00);
        rd(8'd5, v);  check("R1 erased read", v, 8'hFF);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; tb_dq = 8'h3C; tb_drive = 1'b1;
        cyc(2);
        check("R1 bus undriven oe high", dq, 8'h3C);
        ce_n = 1'b1; oe_n = 1'b0;
        cyc(2);
        check("R1 bus undriven ce high", dq, 8'h3C);
        oe_n = 1'b1; tb_drive = 1'b0;
        cyc(1);
    endtask

    task automatic t_ident();
        logic [7:0] v;
        wr('0, 8'h90);
        rd(8'd0, v);  check("R4 manufacturer", v, 8'h01);
        rd(8'd1, v);  check("R4 device", v, 8'hA1);
        rd(8'd2, v);  check("R4 bit0 only", v, 8'h01);
        wr('0, 8'h00);
        rd(8'd0, v);  check("R14 back to array", v, 8'hFF);
    endtask

    task automatic t_program();
        logic [7:0] v;
        wr('0, 8'h40);
        wr(8'd3, 8'h5A);
        check("R6 pulse started", {7'b0, pulse_active}, 8'h01);
        wr('0, 8'hC0);
        check("R7 pulse ended", {7'b0, pulse_active}, 8'h00);
        rd(8'd99, v); check("R7 verify any address", v, 8'h5A);
        wr('0, 8'h40);
        wr(8'd3, 8'hF0);
        wr('0, 8'hC0);
        rd(8'd3, v);  check("R6 and-merge", v, 8'h50);
        wr('0, 8'h00);
        rd(8'd3, v);  check("R6 array read", v, 8'h50);
    endtask

    task automatic t_timer();
        logic [7:0] v;
        wr('0, 8'h40);
        wr(8'd7, 8'h00);
        check("R10 program pulse on", {7'b0, pulse_active}, 8'h01);
        cyc(PRG_CYC + 5);
        check("R10 program pulse self-ended", {7'b0, pulse_active}, 8'h00);
        rd(8'd7, v);  check("R6 programmed to zero", v, 8'h00);
        wr('0, 8'hC0);
        wr('0, 8'h00);
    endtask

    task automatic t_erase();
        logic [7:0] v;
        wr('0, 8'h20);
        wr('0, 8'h20);
        check("R5 erase pulse on", {7'b0, pulse_active}, 8'h01);
        wr('0, 8'h90);
        check("R9 pulse ignores other cmd", {7'b0, pulse_active}, 8'h01);
        rd(8'd1, v);  check("R9 mode unchanged by 90h", v, 8'hFF);
        wr(8'd3, 8'hA0);
        check("R8 erase pulse ended", {7'b0, pulse_active}, 8'h00);
        rd(8'd0, v);  check("R8 verify byte 3", v, 8'hFF);
        wr(8'd7, 8'hA0);
        rd(8'd0, v);  check("R8 verify byte 7", v, 8'hFF);
        wr('0, 8'h00);
        wr('0, 8'h20);
        cyc(ERS_CYC / 2);
        wr('0, 8'h20);
        cyc(ERS_CYC + 5);
        check("R10 erase pulse self-ended", {7'b0, pulse_active}, 8'h00);
        wr('0, 8'hA0);
        wr('0, 8'h00);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        wr('0, 8'h20);
        wr('0, 8'h90);
        check("R5 abort no pulse", {7'b0, pulse_active}, 8'h00);
        rd(8'd1, v);  check("R5 abort to array read", v, 8'hFF);
    endtask

    task automatic t_hv();
        logic [7:0] v;
        hv_ok = 1'b0;
        wr('0, 8'h40);
        wr(8'd9, 8'h00);
        check("R3 no pulse without hv", {7'b0, pulse_active}, 8'h00);
        wr('0, 8'h90);
        rd(8'd0, v);  check("R3 mode unchanged", v, 8'hFF);
        rd(8'd9, v);  check("R3 array unchanged", v, 8'hFF);
        hv_ok = 1'b1;
        cyc(2);
    endtask

    task automatic t_reset_cmd();
        logic [7:0] v;
        wr('0, 8'h90);
        wr('0, 8'hFF);
        rd(8'd1, v);  check("R11 single FFh no effect", v, 8'hA1);
        wr('0, 8'hFF);
        rd(8'd1, v);  check("R11 double FFh to read", v, 8'hFF);
    endtask

    task automatic t_lockout();
        logic [7:0] v;
        wr('0, 8'h90);
        @(negedge clk); supply_ok = 1'b0;
        cyc(3);         supply_ok = 1'b1;
        rd(8'd1, v);  check("R12 lockout to read", v, 8'hFF);
        wr('0, 8'h40);
        wr(8'd5, 8'h0F);
        check("R12 pulse before lockout", {7'b0, pulse_active}, 8'h01);
        @(negedge clk); supply_ok = 1'b0;
        cyc(2);
        check("R12 pulse killed", {7'b0, pulse_active}, 8'h00);
        supply_ok = 1'b1;
        cyc(2);
    endtask

    task automatic t_oe_block();
        logic [7:0] v;
        @(negedge clk);
        addr = '0; tb_dq = 8'h90; tb_drive = 1'b1; oe_n = 1'b0;
        ce_n = 1'b0; we_n = 1'b0;
        cyc(5);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        cyc(1); tb_drive = 1'b0;
        cyc(4);
        rd(8'd0, v);  check("R2 oe low blocks write", v, 8'hFF);
        wr('0, 8'h90);
        rd(8'd0, v);  check("R2 normal write accepted", v, 8'h01);
        wr('0, 8'h00);
    endtask

    task automatic t_powerup();
        logic [7:0] v;
        do_reset(1'b1);
        cyc(4);
        we_n = 1'b1;
        cyc(3);
        ce_n = 1'b1;
        cyc(1); tb_drive = 1'b0;
        cyc(4);
        rd(8'd0, v);  check("R13 held write ignored", v, 8'hFF);
    endtask

    initial begin
        do_reset(1'b0);
        t_reset_state();
        t_ident();
        t_program();
        t_timer();
        t_erase();
        t_abort();
        t_hv();
        t_reset_cmd();
        t_lockout();
        t_oe_block();
        t_powerup();
        done = 1'b1;
    end

    initial begin
        int cnt = 0;
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule